// File: doc/BRIEF.md
# Fractional baud tick generator

This block produces the oversampling enable pulse that a UART receiver and transmitter run from. It counts cycles of a fixed 120 MHz reference clock and divides that clock by a programmable ratio. The ratio is an integer part of 14 bits plus a fraction in sixteenths. The fraction is realised by dithering: a small phase accumulator gathers the fraction once per output period, and each time it wraps the next period is stretched by one reference cycle. Over sixteen periods the average division is therefore exactly the integer plus the fraction.

Software writes a setting with a one-cycle load strobe. A setting loaded while the generator is running is held back until the current period ends, so the UART never sees a shortened period. An oversampling select input tells the block whether the UART samples at 16x or 10x. From that select and the divisor, the block works out the baud rate that would result. It raises an error flag when that rate cannot be supported. The pulse train keeps running at the computed rate even while the flag is up.

Top module: `frac_baud_gen`

## Requirements
- R1: During reset and after reset, `tick` and `cfg_err` are low, and `tick` stays low until the first load strobe.
- R2: When the first load after reset is sampled at clock edge E, `tick` is low in the cycle after E and high in the second cycle after E.
- R3: With fraction 0 and integer divisor N >= 1, consecutive tick cycles are exactly N cycles apart. For N >= 2 the pulse is one cycle wide. For N = 1, `tick` is high in every cycle.
- R4: An integer divisor of 0 gives exactly the same tick timing as a divisor of 1.
- R5: With fraction f (in sixteenths) and effective divisor N, period k after a setting takes effect (k = 1, 2, ...) lasts N+1 cycles when floor(k*f/16) > floor((k-1)*f/16), and N cycles otherwise. The accumulator starts from zero for each newly applied setting.
- R6: A setting loaded in the middle of a period does not change that period; the new setting governs only the periods that follow the next tick.
- R7: A second load before the pending setting is applied replaces it entirely, including its divisor, fraction and oversampling select.
- R8: `os_x10` = 0 selects 16x and 1 selects 10x. The rate is 1 920 000 000 / (os * (16*N + f)), where N is the effective divisor. `cfg_err` is 1 when this rate is above 12 000 000, below 183, or rounds (half up) to 7, 9, 10 or 11 Mbaud.
- R9: `cfg_err` changes at the same clock edge at which a new setting takes over the tick timing, and `tick` keeps running at the computed rate while `cfg_err` is 1.
- R10: The oversampling select affects only `cfg_err` and never the tick timing.
- R11: The largest setting (divisor 16383, fraction 15) gives periods of 16383 and 16384 cycles as R5 dictates, and flags no error in either oversampling mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (120 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| div_int | input | 14 | Integer part of the division ratio; 0 acts as 1 |
| div_frac | input | 4 | Fractional part of the ratio, in sixteenths |
| os_x10 | input | 1 | Oversampling select: 0 = 16x, 1 = 10x |
| load | input | 1 | One-cycle strobe that captures div_int, div_frac and os_x10 |
| tick | output | 1 | Oversampling enable pulse |
| cfg_err | output | 1 | The applied setting gives an unsupported baud rate |

## Verification
The bench sweeps every fraction with several small divisors, including 0 and 1, in both oversampling modes. It compares every period with the dither pattern. An accumulator that started from a stale phase, or a carry applied one period late, would shift where the stretched periods fall. The divisor-1 case catches a design that drops the pulse between back-to-back ticks or counts one cycle too many. Loads placed mid-period and doubled loads check that the running period keeps its old length and that the last write wins. The error flag is checked against a floating-point rate computed in the bench. That covers the exact 7.5 Mbaud rounding edge, which must not be flagged, the 12 Mbaud ceiling, and the largest divisor. A design with an off-by-one band edge would flag or miss one of these.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int unsigned DEF_INT_W    = 14;
  localparam int unsigned DEF_FRAC_W   = 4;
  localparam int unsigned DEF_REF_HZ   = 120_000_000;
  localparam int unsigned DEF_MAX_BAUD = 12_000_000;
  localparam int unsigned DEF_MIN_BAUD = 183;

  localparam int unsigned OS_WIDE   = 16;
  localparam int unsigned OS_NARROW = 10;

  localparam int unsigned MBAUD_UNIT = 1_000_000;
  localparam int unsigned BAD_CNT    = 4;
  localparam int unsigned BAD_MBAUD [BAD_CNT] = '{7, 9, 10, 11};

  typedef enum logic {
    OS_16X = 1'b0,
    OS_10X = 1'b1
  } os_sel_e;

endpackage

// File: rtl/baud_cfg_hold.sv
module baud_cfg_hold #(
  parameter int unsigned INT_W  = baud_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = baud_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [INT_W-1:0]  in_int,
  input  logic [FRAC_W-1:0] in_frac,
  input  logic              in_x10,
  input  logic              tick,
  output logic              run,
  output logic              xfer,
  output logic [INT_W-1:0]  pend_int,
  output logic [FRAC_W-1:0] pend_frac,
  output logic              pend_x10,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_frac
);

  logic              pend_q, pend_d;
  logic              run_q, run_d;
  logic [INT_W-1:0]  pint_q;
  logic [FRAC_W-1:0] pfrac_q;
  logic              px10_q;
  logic [INT_W-1:0]  aint_q;
  logic [FRAC_W-1:0] afrac_q;
  logic              xfer_w;

  // A held setting moves over at a period boundary, or at once when idle.
  always_comb begin
    xfer_w = pend_q && (tick || !run_q);
    pend_d = load ? 1'b1 : (xfer_w ? 1'b0 : pend_q);
    run_d  = run_q | xfer_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      run_q  <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pint_q  <= '0;
      pfrac_q <= '0;
      px10_q  <= 1'b0;
    end else if (load) begin
      pint_q  <= in_int;
      pfrac_q <= in_frac;
      px10_q  <= in_x10;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aint_q  <= '0;
      afrac_q <= '0;
    end else if (xfer_w) begin
      aint_q  <= pint_q;
      afrac_q <= pfrac_q;
    end
  end

  assign run       = run_q;
  assign xfer      = xfer_w;
  assign pend_int  = pint_q;
  assign pend_frac = pfrac_q;
  assign pend_x10  = px10_q;
  assign act_int   = aint_q;
  assign act_frac  = afrac_q;

endmodule

// File: rtl/baud_div_core.sv
module baud_div_core #(
  parameter int unsigned INT_W  = baud_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = baud_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              xfer,
  input  logic [INT_W-1:0]  pend_int,
  input  logic [FRAC_W-1:0] pend_frac,
  input  logic [INT_W-1:0]  act_int,
  input  logic [FRAC_W-1:0] act_frac,
  output logic              tick,
  output logic [INT_W-1:0]  cnt_o,
  output logic [FRAC_W-1:0] acc_o
);

  logic [INT_W-1:0]  cnt_q, cnt_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic              cnt_en;
  logic              tick_w;

  logic [INT_W-1:0]  src_int;
  logic [FRAC_W-1:0] src_frac;
  logic [FRAC_W-1:0] acc_base;
  logic [INT_W-1:0]  n_eff;
  logic [FRAC_W-1:0] acc_sum;
  logic              carry;
  logic [INT_W-1:0]  reload;

  assign tick_w = run && (cnt_q == '0);

  // Length of the next period; a new setting restarts the phase at zero.
  always_comb begin
    src_int            = xfer ? pend_int : act_int;
    src_frac           = xfer ? pend_frac : act_frac;
    acc_base           = xfer ? '0 : acc_q;
    n_eff              = (src_int == '0) ? INT_W'(1) : src_int;
    {carry, acc_sum}   = {1'b0, acc_base} + {1'b0, src_frac};
    reload             = n_eff - INT_W'(1) + INT_W'(carry);
  end

  always_comb begin
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    cnt_en = run || xfer;
    if (xfer && !run) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (tick_w) begin
      cnt_d = reload;
      acc_d = acc_sum;
    end else if (run) begin
      cnt_d = cnt_q - INT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  assign tick  = tick_w;
  assign cnt_o = cnt_q;
  assign acc_o = acc_q;

endmodule

// File: rtl/baud_rate_check.sv
module baud_rate_check #(
  parameter int unsigned INT_W    = baud_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W   = baud_pkg::DEF_FRAC_W,
  parameter int unsigned REF_HZ   = baud_pkg::DEF_REF_HZ,
  parameter int unsigned MAX_BAUD = baud_pkg::DEF_MAX_BAUD,
  parameter int unsigned MIN_BAUD = baud_pkg::DEF_MIN_BAUD
) (
  input  logic [INT_W-1:0]  cand_int,
  input  logic [FRAC_W-1:0] cand_frac,
  input  logic              cand_x10,
  output logic              bad
);
  import baud_pkg::*;

  // rate = NUM / prod, prod = oversampling * divisor in sixteenths
  localparam logic [63:0] NUM  = 64'(REF_HZ) << FRAC_W;
  localparam logic [63:0] NUM2 = NUM << 1;

  os_sel_e          sel;
  logic [INT_W-1:0] n_eff;
  logic [63:0]      d_sub;
  logic [63:0]      prod;
  logic             too_fast;
  logic             too_slow;
  logic [BAD_CNT-1:0] hit;

  assign sel      = os_sel_e'(cand_x10);
  assign n_eff    = (cand_int == '0) ? INT_W'(1) : cand_int;
  assign d_sub    = 64'({n_eff, cand_frac});
  assign prod     = (sel == OS_10X) ? d_sub * 64'(OS_NARROW) : d_sub * 64'(OS_WIDE);
  assign too_fast = NUM > 64'(MAX_BAUD) * prod;
  assign too_slow = NUM < 64'(MIN_BAUD) * prod;

  // Rounded-to-megabaud bands: [M - 0.5, M + 0.5) Mbaud
  for (genvar g = 0; g < BAD_CNT; g++) begin : g_band
    localparam logic [63:0] LO2 = 64'(2 * BAD_MBAUD[g] - 1) * 64'(MBAUD_UNIT);
    localparam logic [63:0] HI2 = 64'(2 * BAD_MBAUD[g] + 1) * 64'(MBAUD_UNIT);
    assign hit[g] = (NUM2 >= LO2 * prod) && (NUM2 < HI2 * prod);
  end

  assign bad = too_fast | too_slow | (|hit);

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int unsigned INT_W    = baud_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W   = baud_pkg::DEF_FRAC_W,
  parameter int unsigned REF_HZ   = baud_pkg::DEF_REF_HZ,
  parameter int unsigned MAX_BAUD = baud_pkg::DEF_MAX_BAUD,
  parameter int unsigned MIN_BAUD = baud_pkg::DEF_MIN_BAUD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic              os_x10,
  input  logic              load,
  output logic              tick,
  output logic              cfg_err
);

  logic              run_w;
  logic              xfer_w;
  logic [INT_W-1:0]  pend_int_w;
  logic [FRAC_W-1:0] pend_frac_w;
  logic              pend_x10_w;
  logic [INT_W-1:0]  act_int_w;
  logic [FRAC_W-1:0] act_frac_w;
  logic [INT_W-1:0]  cnt_w;
  logic [FRAC_W-1:0] acc_w;
  logic              tick_w;
  logic              bad_w;
  logic              err_q, err_d;

  baud_cfg_hold #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .in_int    (div_int),
    .in_frac   (div_frac),
    .in_x10    (os_x10),
    .tick      (tick_w),
    .run       (run_w),
    .xfer      (xfer_w),
    .pend_int  (pend_int_w),
    .pend_frac (pend_frac_w),
    .pend_x10  (pend_x10_w),
    .act_int   (act_int_w),
    .act_frac  (act_frac_w)
  );

  baud_div_core #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_w),
    .xfer      (xfer_w),
    .pend_int  (pend_int_w),
    .pend_frac (pend_frac_w),
    .act_int   (act_int_w),
    .act_frac  (act_frac_w),
    .tick      (tick_w),
    .cnt_o     (cnt_w),
    .acc_o     (acc_w)
  );

  baud_rate_check #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .REF_HZ(REF_HZ),
    .MAX_BAUD(MAX_BAUD), .MIN_BAUD(MIN_BAUD)
  ) u_rate (
    .cand_int  (pend_int_w),
    .cand_frac (pend_frac_w),
    .cand_x10  (pend_x10_w),
    .bad       (bad_w)
  );

  // Error verdict follows the setting that is taking over the timing.
  always_comb begin
    err_d = xfer_w ? bad_w : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign tick    = tick_w;
  assign cfg_err = err_q;

endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
  parameter int unsigned INT_W  = baud_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = baud_pkg::DEF_FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              cfg_err,
  input logic              run,
  input logic              xfer,
  input logic [INT_W-1:0]  cnt,
  input logic [FRAC_W-1:0] acc,
  input logic [INT_W-1:0]  act_int
);

  logic [INT_W-1:0] eff_chk;
  assign eff_chk = (act_int == '0) ? INT_W'(1) : act_int;

  // R1: quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!tick && !cfg_err)
        else $error("tick or cfg_err high during reset");
    end
  end

  // R1: no pulse before a setting has been applied
  a_r1_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  // R3: the remaining count never exceeds the applied period
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= eff_chk);

  // R5: the dither phase only advances on a pulse
  a_r5_acc_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(acc));

  // R6: the applied divisor changes only at a period boundary or from idle
  a_r6_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_int) |-> $past(tick || !run));

  // R9: the error flag moves only with a setting change
  a_r9_err_with_setting: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_err) |-> $past(xfer));

endmodule

bind frac_baud_gen baud_gen_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .cfg_err (cfg_err),
  .run     (run_w),
  .xfer    (xfer_w),
  .cnt     (cnt_w),
  .acc     (acc_w),
  .act_int (act_int_w)
);

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;

  logic        clk;
  logic        rst_n;
  logic [13:0] div_int;
  logic [3:0]  div_frac;
  logic        os_x10;
  logic        load;
  logic        tick;
  logic        cfg_err;

  int checks = 0;
  int fails  = 0;

  frac_baud_gen i_frac_baud_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_int  (div_int),
    .div_frac (div_frac),
    .os_x10   (os_x10),
    .load     (load),
    .tick     (tick),
    .cfg_err  (cfg_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_err(input int n, input int f, input bit m);
    int   neff = (n == 0) ? 1 : n;
    int   d16  = 16 * neff + f;
    real  rate = 1920.0e6 / ((m ? 10.0 : 16.0) * real'(d16));
    int   mb   = int'($floor(rate / 1.0e6 + 0.5));
    return (rate > 12.0e6) || (rate < 183.0) ||
           (mb == 7) || (mb == 9) || (mb == 10) || (mb == 11);
  endfunction

  task automatic do_load(input int n, input int f, input bit m);
    @(negedge clk);
    div_int  = 14'(n);
    div_frac = 4'(f);
    os_x10   = m;
    load     = 1'b1;
    @(negedge clk);
    load     = 1'b0;
  endtask

  task automatic find_boundary();
    while (!tick) @(negedge clk);
  endtask

  // Starts at the negedge of the boundary tick; checks nper periods.
  task automatic measure(input int n, input int f, input bit m,
                         input int nper, input string tag);
    int neff = (n == 0) ? 1 : n;
    bit e    = exp_err(n, f, m);
    for (int k = 1; k <= nper; k++) begin
      int len;
      int ex;
      @(negedge clk);
      len = 1;
      if (k == 1)
        chk(cfg_err === e, "R8 R9", "cfg_err for new setting",
            longint'(cfg_err), longint'(e));
      while (!tick) begin
        @(negedge clk);
        len++;
      end
      ex = neff + ((((k * f) / 16) != (((k - 1) * f) / 16)) ? 1 : 0);
      chk(len == ex, tag, "period length", longint'(len), longint'(ex));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int t;
    int ns [5] = '{0, 1, 2, 3, 7};
    rst_n    = 1'b0;
    div_int  = '0;
    div_frac = '0;
    os_x10   = 1'b0;
    load     = 1'b0;
    repeat (3) @(negedge clk);
    chk(tick === 1'b0 && cfg_err === 1'b0, "R1", "outputs in reset",
        longint'({tick, cfg_err}), 0);
    rst_n = 1'b1;

    // R1: idle after reset
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick !== 1'b0)
        chk(1'b0, "R1", "tick before first load", longint'(tick), 0);
    end
    chk(tick === 1'b0 && cfg_err === 1'b0, "R1", "idle outputs",
        longint'({tick, cfg_err}), 0);

    // R2: first load latency
    do_load(5, 0, 1'b0);
    chk(tick === 1'b0, "R2", "tick one cycle after load edge", longint'(tick), 0);
    @(negedge clk);
    chk(tick === 1'b1, "R2", "tick two cycles after load edge", longint'(tick), 1);
    measure(5, 0, 1'b0, 3, "R3");

    // R3 R4 R5 R10: sweep of divisors, fractions and modes
    for (int m = 0; m < 2; m++) begin
      for (int ni = 0; ni < 5; ni++) begin
        for (int f = 0; f < 16; f++) begin
          string tag;
          tag = (ns[ni] == 0) ? "R4" : ((f == 0) ? "R3" : (m == 1 ? "R10" : "R5"));
          do_load(ns[ni], f, m[0]);
          find_boundary();
          measure(ns[ni], f, m[0], 16, tag);
        end
      end
    end

    // R6: load mid-period keeps the running period whole
    do_load(20, 0, 1'b0);
    find_boundary();
    measure(20, 0, 1'b0, 1, "R6");
    t = 0;
    repeat (6) begin
      @(negedge clk);
      t++;
    end
    div_int  = 14'd3;
    div_frac = 4'd0;
    os_x10   = 1'b0;
    load     = 1'b1;
    @(negedge clk);
    t++;
    load = 1'b0;
    while (!tick) begin
      @(negedge clk);
      t++;
    end
    chk(t == 20, "R6", "period holding the load", longint'(t), 20);
    measure(3, 0, 1'b0, 4, "R6");

    // R7: last of two pending loads wins
    do_load(40, 0, 1'b0);
    find_boundary();
    do_load(9, 0, 1'b1);
    do_load(6, 5, 1'b0);
    t = 4;
    while (!tick) begin
      @(negedge clk);
      t++;
    end
    chk(t == 40, "R7", "period before replaced setting", longint'(t), 40);
    measure(6, 5, 1'b0, 16, "R7");

    // R11: largest setting, both modes
    do_load(16383, 15, 1'b0);
    find_boundary();
    measure(16383, 15, 1'b0, 2, "R11");
    do_load(16383, 15, 1'b1);
    find_boundary();
    measure(16383, 15, 1'b1, 1, "R11");
    chk(cfg_err === 1'b0, "R11", "no error at slowest rate", longint'(cfg_err), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule